// File: doc/BRIEF.md
# Keyed Down-Counting Watchdog Timer

This block is a bus-mapped watchdog. After software enables it, it counts down one step per clock from a power-of-two period. Software must write a fixed key value to a restart register before the count reaches zero. A 4-bit index picks each period. The register holding the indexes has two of them: one for the first load after enable, and one for every later reload. Once the enable bit is set, software cannot clear it. Only the block reset stops the counter.

When the count runs out, the block responds in one of two ways. In direct mode it raises a fixed-length system reset pulse. In interrupt-first mode the first expiry raises an interrupt and restarts the count. If that interrupt is still pending at a second expiry, the reset pulse follows. Reading the interrupt-clear register drops the interrupt and restarts the count. Software can read the live count at any time.

The bus is a plain APB-style slave with no wait states. A transfer takes effect in the access phase, when `psel` and `penable` are both high.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `wdt_rst` and `wdt_irq` are low and reads of control (0x00), index (0x04) and count (0x08) return 0. The count stays at 0 until the block is enabled.
- R2: Writing 1 to control bit 0 while the block is disabled loads the count with 2^(BASE_SHIFT+k), where k is index register bits 7:4. The count then drops by one on each clock.
- R3: Once control bit 0 is 1, a write of 0 to it leaves it at 1. A read of 0x00 returns it in bit 0, with the response mode in bit 1.
- R4: A write of exactly 0x00000076 to 0x0C reloads the count with 2^(BASE_SHIFT+j), where j is index register bits 3:0. Any other value written there leaves the count running undisturbed.
- R5: A read of 0x08 returns the present counter value.
- R6: With control bit 1 at 0, the clock after the count reads zero starts a reset pulse on `wdt_rst` that is exactly RST_CYCLES clocks long.
- R7: With control bit 1 at 1 and no interrupt pending, an expiry sets `wdt_irq` and reloads the count with the bits 3:0 period, without any reset pulse.
- R8: An expiry while `wdt_irq` is still set produces the reset pulse of R6.
- R9: A read of 0x14 returns the pending interrupt in bit 0. It clears `wdt_irq` and reloads the count with the bits 3:0 period.
- R10: After a reset pulse, the count holds at 0 and key writes are ignored. No further pulse occurs until the block reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access phase |
| wdt_irq | output | 1 | Interrupt, level, set by a first expiry in interrupt-first mode |
| wdt_rst | output | 1 | System reset pulse, high for RST_CYCLES clocks |

## Verification
The bench builds the block with BASE_SHIFT=2 and keeps RST_CYCLES at its default of 8. With those values, index 0 expires after 4 clocks and index 6 after 256. That makes both expiries of interrupt-first mode, the full reset pulse and the frozen state after it reachable within a few hundred cycles. The exact expiry cycles and pulse length can then be checked against elapsed-cycle arithmetic kept in the bench. The widest periods are only read back as register values, not run out.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // register byte offsets; software decodes these
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RANGE  = 8'h04;
  localparam logic [7:0] OFS_COUNT  = 8'h08;
  localparam logic [7:0] OFS_KICK   = 8'h0C;
  localparam logic [7:0] OFS_IRQCLR = 8'h14;
  // value that must be written to restart the count
  localparam logic [7:0] KICK_KEY   = 8'h76;
  localparam int         IDX_W      = 4;

  typedef struct packed {
    logic [IDX_W-1:0] init_idx;    // used on the enable edge
    logic [IDX_W-1:0] reload_idx;  // used on every later reload
  } range_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              irq_state,
  output logic              en,
  output logic              mode,
  output range_t            range_q,
  output logic              ev_enable,
  output logic              ev_kick,
  output logic              ev_icr
);
  logic access, wr, rd;
  logic hit_ctrl, hit_range, hit_count, hit_kick, hit_icr;

  assign access    = psel & penable;
  assign wr        = access & pwrite;
  assign rd        = access & ~pwrite;
  assign hit_ctrl  = (paddr == ADDR_W'(OFS_CTRL));
  assign hit_range = (paddr == ADDR_W'(OFS_RANGE));
  assign hit_count = (paddr == ADDR_W'(OFS_COUNT));
  assign hit_kick  = (paddr == ADDR_W'(OFS_KICK));
  assign hit_icr   = (paddr == ADDR_W'(OFS_IRQCLR));

  // internal events brought out as named wires
  assign ev_enable = wr & hit_ctrl & pwdata[0] & ~en;
  assign ev_kick   = wr & hit_kick & (pwdata == DATA_W'(KICK_KEY));
  assign ev_icr    = rd & hit_icr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      mode    <= 1'b0;
      range_q <= '0;
    end else if (wr) begin
      if (hit_ctrl) begin
        en   <= en | pwdata[0];   // set-only
        mode <= pwdata[1];
      end
      if (hit_range) range_q <= range_t'(pwdata[7:0]);
    end
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      if (hit_ctrl)       prdata = DATA_W'({mode, en});
      else if (hit_range) prdata = DATA_W'(range_q);
      else if (hit_count) prdata = DATA_W'(cnt_val);
      else if (hit_icr)   prdata = DATA_W'(irq_state);
    end
  end

  p_enable_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  p_enable_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enable |=> en);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_SHIFT = 16,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             halt,
  input  range_t           range_q,
  input  logic             ev_enable,
  input  logic             ev_kick,
  input  logic             ev_icr,
  input  logic             irq_reload,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_expire
);
  function automatic logic [CNT_W-1:0] period_of(input logic [IDX_W-1:0] idx);
    return CNT_W'(1) << (BASE_SHIFT + int'(idx));
  endfunction

  logic run, sw_reload, any_load;
  assign run       = en & ~halt;
  assign sw_reload = ev_kick | ev_icr;
  assign ev_expire = run & ~sw_reload & (cnt == '0);
  assign any_load  = ev_enable | sw_reload | irq_reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ev_enable) begin
      cnt <= period_of(range_q.init_idx);
    end else if (run) begin
      if (sw_reload || irq_reload) cnt <= period_of(range_q.reload_idx);
      else if (cnt != '0)          cnt <= cnt - 1'b1;
    end
  end

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !any_load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enable |=> (cnt == period_of($past(range_q.init_idx))));
  p_kick_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ev_kick) |=> (cnt == period_of($past(range_q.reload_idx))));
  p_halt_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (cnt == '0));
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic ev_expire,
  input  logic ev_icr,
  output logic irq,
  output logic halt,
  output logic rst_out,
  output logic irq_reload
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] pulse_cnt;
  logic          fire;

  assign irq_reload = ev_expire & mode & ~irq;
  assign fire       = ev_expire & ~irq_reload;
  assign rst_out    = (pulse_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      halt      <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      if (irq_reload)  irq <= 1'b1;
      else if (ev_icr) irq <= 1'b0;
      if (fire) begin
        halt      <= 1'b1;
        pulse_cnt <= PW'(RST_CYCLES);
      end else if (pulse_cnt != '0) begin
        pulse_cnt <= pulse_cnt - 1'b1;
      end
    end
  end

  p_direct_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && !mode && !irq) |=> (rst_out && halt));
  p_irq_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && mode && !irq) |=> (irq && !rst_out));
  p_second_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && irq) |=> rst_out);
  p_icr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_icr && !irq_reload) |=> !irq);
  p_no_refire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !rst_out) |=> !rst_out);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int BASE_SHIFT = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              wdt_irq,
  output logic              wdt_rst
);
  localparam int CNT_W = BASE_SHIFT + (1 << IDX_W);

  logic             en, mode, halt;
  range_t           range_q;
  logic             ev_enable, ev_kick, ev_icr, ev_expire, irq_reload;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .cnt_val(cnt), .irq_state(wdt_irq), .en(en), .mode(mode),
    .range_q(range_q), .ev_enable(ev_enable), .ev_kick(ev_kick),
    .ev_icr(ev_icr)
  );

  wdog_counter #(.BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .halt(halt), .range_q(range_q),
    .ev_enable(ev_enable), .ev_kick(ev_kick), .ev_icr(ev_icr),
    .irq_reload(irq_reload), .cnt(cnt), .ev_expire(ev_expire)
  );

  wdog_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ev_expire(ev_expire),
    .ev_icr(ev_icr), .irq(wdt_irq), .halt(halt), .rst_out(wdt_rst),
    .irq_reload(irq_reload)
  );

  initial begin
    a_width_fits: assert (CNT_W <= DATA_W);
  end
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int SH = 2;
  localparam int RC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        wdt_irq, wdt_rst;

  int errors = 0, checks = 0, cyc = 0, load_cyc = 0;
  bit done = 0;

  wdog_timer #(.BASE_SHIFT(SH), .RST_CYCLES(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int per(input int idx);
    return 1 << (SH + idx);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output int at);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata; at = cyc;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // wait at negedges for irq (which=0) or reset pulse (which=1) to be high
  task automatic wait_high(input int which, output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      if ((which == 0 ? wdt_irq : wdt_rst) == 1'b1) begin at = cyc; break; end
      @(negedge clk);
    end
  endtask

  // init index, reload index, idle clocks before read, expected count
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{1, 0, 0,   6},
    '{2, 5, 5,   9},
    '{4, 1, 20,  42},
    '{6, 3, 100, 154},
    '{0, 7, 1,   1}
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int at, t;
    do_reset();

    // R1 reset state
    chk("R1 rst", wdt_rst, 0);
    chk("R1 irq", wdt_irq, 0);
    rd(8'h00, d, at); chk("R1 ctrl", d, 0);
    rd(8'h04, d, at); chk("R1 range", d, 0);
    repeat (20) @(negedge clk);
    rd(8'h08, d, at); chk("R1 count idle", d, 0);

    // R2/R5 vector table: initial index selects the first period
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(8'h04, 32'((VEC[v][0] << 4) | VEC[v][1]));
      wr(8'h00, 32'h1);
      repeat (VEC[v][2]) @(negedge clk);
      rd(8'h08, d, at);
      chk("R2/R5 count vector", d, VEC[v][3]);
    end

    // R3 enable is sticky
    do_reset();
    wr(8'h04, 32'h53);           // init 5 (128), reload 3 (32)
    wr(8'h00, 32'h1); load_cyc = cyc;
    wr(8'h00, 32'h0);
    rd(8'h00, d, at); chk("R3 enable sticky", d[0], 1);
    rd(8'h08, d, at); chk("R3 still counting", d, per(5) - (at - load_cyc));

    // R4 wrong keys ignored
    wr(8'h0C, 32'h75);
    wr(8'h0C, 32'h176);
    rd(8'h08, d, at); chk("R4 bad key ignored", d, per(5) - (at - load_cyc));
    // R4 good key reloads with reload index
    wr(8'h0C, 32'h76); load_cyc = cyc;
    rd(8'h08, d, at); chk("R4 kick reload", d, per(3) - (at - load_cyc));

    // R6 direct reset mode
    do_reset();
    wr(8'h04, 32'h00);
    wr(8'h00, 32'h1); load_cyc = cyc;
    wait_high(1, at);
    chk("R6 reset rise cycle", at, load_cyc + per(0) + 1);
    t = 0;
    while (wdt_rst && t < 50) begin t++; @(negedge clk); end
    chk("R6 pulse width", t, RC);
    chk("R6 no irq", wdt_irq, 0);
    // R10 frozen after reset fired
    rd(8'h08, d, at); chk("R10 count held", d, 0);
    wr(8'h0C, 32'h76);
    rd(8'h08, d, at); chk("R10 kick ignored", d, 0);
    t = 0;
    repeat (30) begin @(negedge clk); if (wdt_rst) t++; end
    chk("R10 no second pulse", t, 0);
    do_reset();
    chk("R1 rst after block reset", wdt_rst, 0);
    rd(8'h00, d, at); chk("R1 ctrl after block reset", d, 0);

    // R7/R8 interrupt first, then reset
    wr(8'h04, 32'h01);           // init 0 (4), reload 1 (8)
    wr(8'h00, 32'h3); load_cyc = cyc;
    wait_high(0, at);
    chk("R7 irq rise cycle", at, load_cyc + per(0) + 1);
    chk("R7 no reset yet", wdt_rst, 0);
    rd(8'h00, d, at); chk("R7 mode readback", d[1:0], 3);
    wait_high(1, t);
    chk("R8 second expiry reset", t, load_cyc + per(0) + 1 + per(1) + 1);

    // R9 interrupt clear read
    do_reset();
    wr(8'h04, 32'h04);           // init 0 (4), reload 4 (64)
    wr(8'h00, 32'h3); load_cyc = cyc;
    wait_high(0, at);
    chk("R9 irq pending", wdt_irq, 1);
    rd(8'h14, d, at); chk("R9 clear read value", d[0], 1);
    load_cyc = at + 1;
    chk("R9 irq cleared", wdt_irq, 0);
    rd(8'h08, d, at); chk("R9 reload", d, per(4) - (at - load_cyc));
    rd(8'h14, d, at); chk("R9 second read", d[0], 0);
    chk("R9 no reset", wdt_rst, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule